// File: doc/BRIEF.md
# Register-Budgeted Interleaved Batch Issuer

This block drives the issue port of a coupled arithmetic/texture pipeline of fixed depth. A batch of fragments is issued in quads, one quad group per clock, in strict round-robin order. Every group must issue the current instruction before any group may issue the next one. The number of groups in a batch is not fixed. It is worked out at each start from a fixed register-file capacity and the number of registers each fragment needs. A lighter register budget gives a larger batch.

When the shader samples textures, a group may not return to the pipeline until its previous operation has made a full pass through it. A batch with fewer groups than the pipeline depth therefore cannot fill every slot. The block pads each instruction round with explicit bubble cycles. At half the default batch size, half of the cycles become bubbles. A shader without texture fetches needs no such spacing, and its groups issue back to back. Two counters report the issue cycles and bubble cycles of the most recent batch.

Top module: `batch_issuer`

## Requirements
- R1: The group count of a batch is RF_REGS / (regs_per_frag * QUAD_SIZE). With the defaults (RF_REGS = 3520, QUAD_SIZE = 4) this gives 440 groups for a budget of 2, 220 groups for 4 and 110 groups for 8. Over the batch, issue_cnt reaches instr_count times this group count.
- R2: A start that is accepted while idle, with a valid configuration, shows issue_vld high for group 0 of instruction 0 in the very next cycle. The block then issues at most one group per clock.
- R3: Within an instruction, groups issue in ascending order from 0 to G-1 on consecutive cycles. Instruction k+1 begins only after group G-1 has issued instruction k.
- R4: When tex_used = 1 and G < PIPE_DEPTH (default 220), exactly PIPE_DEPTH - G bubble cycles follow the last group of every instruction except the final one. These bubbles show as bubble = 1 and issue_vld = 0. As a result, a group issues consecutive instructions exactly PIPE_DEPTH clocks apart. No bubble follows the final instruction.
- R5: When tex_used = 0, or when G >= PIPE_DEPTH, no bubble cycle occurs. Rounds follow one another with no gap.
- R6: busy is high from the cycle after an accepted start until the cycle of the final issue. In the cycle after the final issue, done = 1 and busy = 0. done then holds until the next start is taken while idle.
- R7: A start while idle is rejected when regs_per_frag is not 2, 4 or 8, or when instr_count = 0. In the next cycle cfg_err = 1, busy = 0 and done = 0, and no issue occurs. The counters keep their values. The next valid start clears cfg_err.
- R8: A start raised while busy is ignored. The running schedule continues unchanged, and new values on the configuration inputs have no effect.
- R9: An accepted valid start clears issue_cnt and bubble_cnt. After that, each issue cycle adds one to issue_cnt and each bubble cycle adds one to bubble_cnt. Both counters hold their values once the batch is done.
- R10: After reset, issue_vld, bubble, busy, done and cfg_err are 0, and both counters read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin a batch (taken only when idle) |
| regs_per_frag | input | 4 | Registers each fragment needs (2, 4 or 8) |
| instr_count | input | INSTR_W | Number of instructions in the shader |
| tex_used | input | 1 | 1 if the shader fetches textures (requires latency spacing) |
| issue_vld | output | 1 | A group issues in this cycle |
| issue_group | output | GRP_W | Index of the issuing quad group |
| issue_instr | output | INSTR_W | Index of the instruction being issued |
| bubble | output | 1 | This cycle is a padding bubble |
| busy | output | 1 | A batch is in progress |
| done | output | 1 | The last batch has completed |
| cfg_err | output | 1 | The last start was rejected |
| issue_cnt | output | CNT_W | Issue cycles in the current or last batch |
| bubble_cnt | output | CNT_W | Bubble cycles in the current or last batch |

## Verification
A corrupted slot or instruction register shows up at the issue port in the cycle that follows. It produces a skipped or repeated group index, a bubble where an issue was due, or an instruction index that advances too early. All of these break the per-cycle comparison against the expected schedule. A wrong latched group count or round length appears at the first round boundary, which comes at most 440 clocks after start, as a misplaced bubble run or an early wrap. A wrong counter or done flag is caught in the first cycle after the final issue.

// File: rtl/batch_issuer_pkg.sv
package batch_issuer_pkg;

   // Register budgets the issuer accepts.
   typedef enum logic [1:0] {
      BUDGET_2   = 2'd0,
      BUDGET_4   = 2'd1,
      BUDGET_8   = 2'd2,
      BUDGET_BAD = 2'd3
   } budget_e;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   function automatic budget_e classify_budget(input logic [3:0] regs);
      budget_e b;
      case (regs)
         4'd2:    b = BUDGET_2;
         4'd4:    b = BUDGET_4;
         4'd8:    b = BUDGET_8;
         default: b = BUDGET_BAD;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/batch_issuer_budget.sv
module batch_issuer_budget
   import batch_issuer_pkg::*;
#(
   parameter int RF_REGS    = 3520,
   parameter int QUAD_SIZE  = 4,
   parameter int PIPE_DEPTH = 220,
   parameter int INSTR_W    = 8,
   parameter int SLOT_W     = 9
) (
   input  logic [3:0]         regs_per_frag,
   input  logic [INSTR_W-1:0] instr_count,
   input  logic               tex_used,
   output logic [SLOT_W-1:0]  groups,
   output logic [SLOT_W-1:0]  round_len,
   output logic               cfg_ok
);

   localparam int GROUPS_2 = RF_REGS / (2 * QUAD_SIZE);
   localparam int GROUPS_4 = RF_REGS / (4 * QUAD_SIZE);
   localparam int GROUPS_8 = RF_REGS / (8 * QUAD_SIZE);

   budget_e budget;

   always_comb begin
      budget = classify_budget(regs_per_frag);
      cfg_ok = (budget != BUDGET_BAD) && (instr_count != '0);
      case (budget)
         BUDGET_2: groups = SLOT_W'(GROUPS_2);
         BUDGET_4: groups = SLOT_W'(GROUPS_4);
         BUDGET_8: groups = SLOT_W'(GROUPS_8);
         default:  groups = '0;
      endcase
   end

   // The round length is the group count, stretched to the pipeline
   // depth when texture latency has to be hidden.
   generate
      if (PIPE_DEPTH >= GROUPS_2) begin : g_depth_dominates
         // Every legal batch is at or below the depth: no compare needed.
         always_comb
            round_len = tex_used ? SLOT_W'(PIPE_DEPTH) : groups;
      end else begin : g_general
         always_comb begin
            if (tex_used && (groups < SLOT_W'(PIPE_DEPTH)))
               round_len = SLOT_W'(PIPE_DEPTH);
            else
               round_len = groups;
         end
      end
   endgenerate

endmodule

// File: rtl/batch_issuer_seq.sv
module batch_issuer_seq
   import batch_issuer_pkg::*;
#(
   parameter int INSTR_W = 8,
   parameter int SLOT_W  = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               cfg_ok,
   input  logic [SLOT_W-1:0]  groups,
   input  logic [SLOT_W-1:0]  round_len,
   input  logic [INSTR_W-1:0] instr_count,
   output logic               accept,
   output logic               issue_vld,
   output logic               bubble,
   output logic [SLOT_W-1:0]  slot,
   output logic [INSTR_W-1:0] instr,
   output logic               busy,
   output logic               done,
   output logic               cfg_err
);

   seq_state_e         state_q;
   logic [SLOT_W-1:0]  slot_q;
   logic [SLOT_W-1:0]  groups_q;
   logic [SLOT_W-1:0]  round_q;
   logic [INSTR_W-1:0] instr_q;
   logic [INSTR_W-1:0] last_instr_q;
   logic               done_q;
   logic               err_q;
   logic               take;
   logic               final_issue;
   logic               round_end;

   assign take        = start && (state_q == SEQ_IDLE);
   assign accept      = take && cfg_ok;
   assign busy        = (state_q == SEQ_RUN);
   assign issue_vld   = busy && (slot_q < groups_q);
   assign bubble      = busy && (slot_q >= groups_q);
   assign final_issue = issue_vld && (slot_q == groups_q - SLOT_W'(1))
                        && (instr_q == last_instr_q);
   assign round_end   = (slot_q == round_q - SLOT_W'(1));
   assign slot        = slot_q;
   assign instr       = instr_q;
   assign done        = done_q;
   assign cfg_err     = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= SEQ_IDLE;
         slot_q       <= '0;
         groups_q     <= '0;
         round_q      <= '0;
         instr_q      <= '0;
         last_instr_q <= '0;
         done_q       <= 1'b0;
         err_q        <= 1'b0;
      end else if (take) begin
         done_q <= 1'b0;
         if (cfg_ok) begin
            state_q      <= SEQ_RUN;
            err_q        <= 1'b0;
            slot_q       <= '0;
            instr_q      <= '0;
            groups_q     <= groups;
            round_q      <= round_len;
            last_instr_q <= instr_count - INSTR_W'(1);
         end else begin
            err_q <= 1'b1;
         end
      end else if (busy) begin
         if (final_issue) begin
            state_q <= SEQ_IDLE;
            done_q  <= 1'b1;
         end else if (round_end) begin
            slot_q  <= '0;
            instr_q <= instr_q + INSTR_W'(1);
         end else begin
            slot_q <= slot_q + SLOT_W'(1);
         end
      end
   end

   // R3
   grp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_vld && (slot_q < groups_q - SLOT_W'(1)))
      |=> (issue_vld && (slot_q == $past(slot_q) + SLOT_W'(1))
           && (instr_q == $past(instr_q))));

   // R4
   bubble_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bubble |=> (bubble || (issue_vld && (slot_q == '0)
                             && (instr_q == $past(instr_q) + INSTR_W'(1)))));

   // R6
   done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      final_issue |=> (done && !busy && !issue_vld));

   // R7
   reject_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !cfg_ok) |=> (err_q && !busy && !done_q));

   // R8
   busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !final_issue)
      |=> (busy && $stable(groups_q) && $stable(round_q) && $stable(last_instr_q)));

   // R2
   first_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (issue_vld && (slot_q == '0) && (instr_q == '0)));

endmodule

// File: rtl/batch_issuer_cnt.sv
module batch_issuer_cnt #(
   parameter int CNT_W    = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] value
);

   logic [CNT_W-1:0] value_q;
   logic             may_inc;

   generate
      if (SATURATE) begin : g_sat
         assign may_inc = inc && (value_q != {CNT_W{1'b1}});
      end else begin : g_wrap
         assign may_inc = inc;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         value_q <= '0;
      else if (clr)
         value_q <= '0;
      else if (may_inc)
         value_q <= value_q + CNT_W'(1);
   end

   assign value = value_q;

   // R9
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && (value_q != {CNT_W{1'b1}}))
      |=> (value_q == $past(value_q) + CNT_W'(1)));

   // R9
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !clr) |=> $stable(value_q));

endmodule

// File: rtl/batch_issuer.sv
module batch_issuer
   import batch_issuer_pkg::*;
#(
   parameter int RF_REGS    = 3520,
   parameter int QUAD_SIZE  = 4,
   parameter int PIPE_DEPTH = 220,
   parameter int INSTR_W    = 8,
   parameter int CNT_W      = 32,
   parameter bit CNT_SAT    = 1'b1,
   parameter int GRP_W      = $clog2(RF_REGS / (2 * QUAD_SIZE) + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [3:0]         regs_per_frag,
   input  logic [INSTR_W-1:0] instr_count,
   input  logic               tex_used,
   output logic               issue_vld,
   output logic [GRP_W-1:0]   issue_group,
   output logic [INSTR_W-1:0] issue_instr,
   output logic               bubble,
   output logic               busy,
   output logic               done,
   output logic               cfg_err,
   output logic [CNT_W-1:0]   issue_cnt,
   output logic [CNT_W-1:0]   bubble_cnt
);

   localparam int DEPTH_W = $clog2(PIPE_DEPTH + 1);
   localparam int SLOT_W  = (GRP_W > DEPTH_W) ? GRP_W : DEPTH_W;

   // Elaboration-time parameter checks
   generate
      if (RF_REGS % (8 * QUAD_SIZE) != 0) begin : g_bad_rf
         $error("RF_REGS must divide evenly by 8 * QUAD_SIZE");
      end
      if (PIPE_DEPTH < 1) begin : g_bad_depth
         $error("PIPE_DEPTH must be at least 1");
      end
      if (QUAD_SIZE < 1) begin : g_bad_quad
         $error("QUAD_SIZE must be at least 1");
      end
      if (INSTR_W < 1 || CNT_W < 2) begin : g_bad_width
         $error("INSTR_W and CNT_W are too narrow");
      end
      if ((1 << GRP_W) <= RF_REGS / (2 * QUAD_SIZE)) begin : g_bad_grp
         $error("GRP_W cannot hold the largest group index");
      end
   endgenerate

   logic [SLOT_W-1:0] groups;
   logic [SLOT_W-1:0] round_len;
   logic              cfg_ok;
   logic              accept;
   logic [SLOT_W-1:0] slot;

   batch_issuer_budget #(
      .RF_REGS    (RF_REGS),
      .QUAD_SIZE  (QUAD_SIZE),
      .PIPE_DEPTH (PIPE_DEPTH),
      .INSTR_W    (INSTR_W),
      .SLOT_W     (SLOT_W)
   ) u_budget (
      .regs_per_frag (regs_per_frag),
      .instr_count   (instr_count),
      .tex_used      (tex_used),
      .groups        (groups),
      .round_len     (round_len),
      .cfg_ok        (cfg_ok)
   );

   batch_issuer_seq #(
      .INSTR_W (INSTR_W),
      .SLOT_W  (SLOT_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .cfg_ok      (cfg_ok),
      .groups      (groups),
      .round_len   (round_len),
      .instr_count (instr_count),
      .accept      (accept),
      .issue_vld   (issue_vld),
      .bubble      (bubble),
      .slot        (slot),
      .instr       (issue_instr),
      .busy        (busy),
      .done        (done),
      .cfg_err     (cfg_err)
   );

   assign issue_group = slot[GRP_W-1:0];

   batch_issuer_cnt #(
      .CNT_W    (CNT_W),
      .SATURATE (CNT_SAT)
   ) u_issue_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .inc   (issue_vld),
      .value (issue_cnt)
   );

   batch_issuer_cnt #(
      .CNT_W    (CNT_W),
      .SATURATE (CNT_SAT)
   ) u_bubble_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .inc   (bubble),
      .value (bubble_cnt)
   );

   // R6
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !issue_vld && !bubble));

   // R9
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> ((issue_cnt == '0) && (bubble_cnt == '0)));

   // R10
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |-> (!busy && !done && !cfg_err && !issue_vld && !bubble));

endmodule

// File: tb/batch_issuer_bench.sv
module batch_issuer_bench;

   localparam int RF       = 3520;
   localparam int QUAD     = 4;
   localparam int DEPTH    = 220;
   localparam int IW       = 8;
   localparam int CW       = 32;
   localparam int GW       = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [3:0]    regs_in = 4'd4;
   logic [IW-1:0] n_in = '0;
   logic          tex_in = 1'b0;
   logic          issue_vld;
   logic [GW-1:0] issue_group;
   logic [IW-1:0] issue_instr;
   logic          bubble;
   logic          busy;
   logic          done;
   logic          cfg_err;
   logic [CW-1:0] issue_cnt;
   logic [CW-1:0] bubble_cnt;

   int vectors = 0;
   int errors  = 0;
   int cycles  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   batch_issuer u_batch_issuer (
      .clk (clk), .rst_n (rst_n), .start (start),
      .regs_per_frag (regs_in), .instr_count (n_in), .tex_used (tex_in),
      .issue_vld (issue_vld), .issue_group (issue_group),
      .issue_instr (issue_instr), .bubble (bubble), .busy (busy),
      .done (done), .cfg_err (cfg_err),
      .issue_cnt (issue_cnt), .bubble_cnt (bubble_cnt)
   );

   task automatic check(input string tag, input bit ok,
                        input longint got, input longint exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s got=%0d exp=%0d at t=%0t", tag, got, exp, $time);
      end
   endtask

   // Expected schedule entry: kind*1_000_000 + instr*1000 + group
   // kind 0 = issue, kind 1 = bubble
   task automatic run_batch(input int regs, input bit tex, input int n,
                            input int poke);
      int q[$];
      int groups, len, exp_i, exp_b, k;
      bit bad;
      longint prev_i, prev_b;
      bad = !(regs == 2 || regs == 4 || regs == 8) || (n == 0);
      prev_i = issue_cnt;
      prev_b = bubble_cnt;
      @(negedge clk);
      regs_in = 4'(regs); tex_in = tex; n_in = IW'(n); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (bad) begin
         check("R7 cfg_err", cfg_err == 1'b1, cfg_err, 1);
         check("R7 idle", !busy && !issue_vld && !done, busy, 0);
         check("R7 counters kept", issue_cnt == prev_i && bubble_cnt == prev_b,
               issue_cnt, prev_i);
         return;
      end
      groups = RF / (regs * QUAD);
      len = (tex && groups < DEPTH) ? DEPTH : groups;
      for (int i = 0; i < n; i++) begin
         for (int g = 0; g < groups; g++) q.push_back(i * 1000 + g);
         if (i < n - 1)
            for (int b = groups; b < len; b++) q.push_back(1000000 + i * 1000 + b);
      end
      exp_i = 0; exp_b = 0; k = 0;
      while (q.size() > 0) begin
         int e, kind, ei, eg;
         string tag;
         e = q.pop_front();
         kind = e / 1000000; ei = (e / 1000) % 1000; eg = e % 1000;
         if (k == 0) tag = "R2 first issue";
         else if (kind == 1) tag = "R4 bubble";
         else if (!tex || groups >= DEPTH) tag = "R5 issue";
         else tag = "R3 issue";
         if (kind == 0) begin
            exp_i++;
            check({tag, " vld/grp/instr"},
                  issue_vld && !bubble && busy && !done &&
                  int'(issue_group) == eg && int'(issue_instr) == ei,
                  longint'(issue_vld) * 1000000 + longint'(issue_instr) * 1000
                     + longint'(issue_group),
                  1000000 + ei * 1000 + eg);
         end else begin
            exp_b++;
            check({tag, " slot"}, bubble && !issue_vld && busy,
                  bubble, 1);
         end
         if (k == poke) begin
            // R8: start while busy with a different configuration
            start = 1'b1; regs_in = 4'd2; tex_in = ~tex; n_in = 8'd1;
         end else if (k == poke + 1) begin
            start = 1'b0; regs_in = 4'(regs); tex_in = tex; n_in = IW'(n);
         end
         @(negedge clk);
         k++;
      end
      start = 1'b0;
      check("R6 done", done && !busy && !issue_vld && !bubble, done, 1);
      check("R1 issue total", int'(issue_cnt) == n * groups, issue_cnt, n * groups);
      check("R9 issue_cnt", int'(issue_cnt) == exp_i, issue_cnt, exp_i);
      check("R9 bubble_cnt", int'(bubble_cnt) == exp_b, bubble_cnt, exp_b);
      check("R7 err cleared", cfg_err == 1'b0, cfg_err, 0);
      @(negedge clk);
      check("R6 done holds", done && !busy, done, 1);
      check("R9 counters hold", int'(issue_cnt) == exp_i && int'(bubble_cnt) == exp_b,
            issue_cnt, exp_i);
   endtask

   initial begin : watchdog
      while (!finished) begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000 && !finished) begin
            errors++;
            $display("FAIL watchdog got=%0d exp=%0d", cycles, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
         end
      end
   end

   initial begin : stimulus
      repeat (3) @(negedge clk);
      check("R10 reset outputs",
            !issue_vld && !bubble && !busy && !done && !cfg_err, busy, 0);
      check("R10 reset counters", issue_cnt == '0 && bubble_cnt == '0, issue_cnt, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 idle after release", !busy && !done, busy, 0);

      run_batch(4, 1'b1, 2, -10);    // default batch fills pipeline
      run_batch(8, 1'b1, 3, 50);     // half batch, bubbles, busy start poke
      run_batch(3, 1'b1, 2, -10);    // bad register budget
      check("R7 done cleared by reject", !done, done, 0);
      run_batch(8, 1'b0, 2, -10);    // no texture: no bubbles
      run_batch(0, 1'b0, 1, -10);    // bad budget zero
      run_batch(4, 1'b1, 0, -10);    // zero instructions
      run_batch(2, 1'b1, 2, 300);    // large batch exceeds depth
      run_batch(4, 1'b0, 1, -10);    // single instruction

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule